// File: doc/BRIEF.md
# Two-Slot Receive Packet Status Controller

This block keeps the software-visible status of a receive endpoint whose buffer can hold up to two complete packets. For each packet delivered by the link side it records the byte count and raises a ready flag. When a second packet arrives before the first has been released, it also raises a full flag. The data path is not part of this block. Software reads a packet out and then releases it. A packet of exactly the maximum payload size is released automatically when its unload completes. A shorter packet must be released by an explicit clear-ready write.

When the second slot is occupied and the head packet is released, full drops first and ready is held low for exactly one cycle. Ready then comes back for the queued packet, and the reported count moves to that packet. When no slot is free, a new packet is refused with a same-cycle NAK indication. A configuration input turns double buffering off, and its source holds it high after reset. While it is high, only one packet is held and full never sets.

States: ST_EMPTY (no packet held), ST_ONE (one packet, ready high), ST_TWO (two packets, ready and full high), ST_SWAP (one-cycle gap after releasing the head of a full buffer, ready and full low). Transitions: EMPTY→ONE on an accepted packet. ONE→TWO on an accepted packet. ONE→EMPTY on a release. ONE→SWAP on a release in the same cycle as an accepted packet. TWO→SWAP on a release. SWAP→ONE by default. SWAP→TWO on an accepted packet.

Top module: `rxbuf_status_ctrl`

## Requirements
- R1: After reset, rdy, full and nak are 0 and head_cnt is 0.
- R2: A pkt_valid strobe while no packet is held makes rdy 1 on the next cycle, with head_cnt equal to the strobed pkt_bytes.
- R3: An unload strobe while rdy is 1 and head_cnt equals MAX_PKT (64 by default) releases the head packet. With a single packet held, rdy is 0 and head_cnt is 0 on the next cycle.
- R4: An unload strobe on a head packet shorter than MAX_PKT leaves rdy at 1. A clr_rdy strobe while rdy is 1 releases the head packet on the next cycle.
- R5: With dbuf_dis 0, a second accepted packet while rdy is 1 sets full to 1 on the next cycle, and head_cnt keeps the first packet's count.
- R6: Releasing the head while full is 1 gives full 0, rdy 0 and head_cnt equal to the second packet's count on the next cycle. On the cycle after that, rdy is 1 and full is 0.
- R7: With dbuf_dis 1, a packet strobed while rdy is 1 gets nak 1 in the same cycle. full stays 0, and rdy and head_cnt are unchanged.
- R8: A packet strobed while full is 1 gets nak 1 in the same cycle. Afterwards rdy, full and head_cnt are unchanged.
- R9: A clr_rdy strobe while rdy is 0 has no effect: an empty controller stays empty, and after a release of a full buffer rdy still returns on the next cycle.
- R10: An unload strobe while rdy is 0 has no effect, including during the one-cycle gap after a release of a full buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | One-cycle strobe: a complete packet has been written |
| pkt_bytes | input | CNT_W | Byte count of the strobed packet |
| unload | input | 1 | One-cycle strobe: software finished reading the head packet |
| clr_rdy | input | 1 | One-cycle strobe: software write that clears ready |
| dbuf_dis | input | 1 | 1 = single-packet mode (held high after reset by its source) |
| rdy | output | 1 | A packet is available to software |
| full | output | 1 | Both slots are occupied |
| head_cnt | output | CNT_W | Byte count of the head packet, 0 when empty |
| nak | output | 1 | Same-cycle refusal of the strobed packet |

## Verification
The bench targets the release of a full buffer. It expects the one-cycle gap with ready low and the count already on the second packet. A design that kept ready high, or that left the old count in place, would fail here. Short-packet unloads must leave ready set, since a design that released on every unload would drop ready too early. Strobes into a full buffer, or into single-packet mode, must raise nak and leave the held counts intact, because a design that overwrote a slot would report the wrong head count. Clear-ready and unload strobes during the gap or while empty are expected to change nothing; a design that acted on them would skip the queued packet.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_ONE   = 2'd1,
        ST_TWO   = 2'd2,
        ST_SWAP  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/rxbuf_slots.sv
module rxbuf_slots #(
    parameter int CNT_W = 7,
    parameter int NSLOT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [CNT_W-1:0] push_cnt,
    input  logic             pop,
    output logic [CNT_W-1:0] slot_head
);
    localparam int PTR_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt_q [NSLOT];

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(NSLOT - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= ptr_inc(wr_ptr);
            if (pop)  rd_ptr <= ptr_inc(rd_ptr);
        end
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cnt_q[g] <= '0;
            else if (push && wr_ptr == PTR_W'(g))
                cnt_q[g] <= push_cnt;
        end
    end

    assign slot_head = cnt_q[rd_ptr];
endmodule

// File: rtl/rxbuf_fsm.sv
module rxbuf_fsm
    import rxbuf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pkt_valid,
    input  logic      unload,
    input  logic      clr_rdy,
    input  logic      dbuf_dis,
    input  logic      head_is_max,
    output rx_state_e state,
    output logic      push,
    output logic      pop,
    output logic      nak,
    output logic      rdy,
    output logic      full
);
    rx_state_e state_nx;
    logic      release_hd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nx;
    end

    always_comb begin
        rdy  = 1'b0;
        full = 1'b0;
        unique case (state)
            ST_EMPTY: ;
            ST_ONE:   rdy = 1'b1;
            ST_TWO:   begin rdy = 1'b1; full = 1'b1; end
            ST_SWAP:  ;
        endcase
    end

    always_comb begin
        release_hd = rdy && (clr_rdy || (unload && head_is_max));
        nak  = pkt_valid && ((state == ST_TWO) ||
               (dbuf_dis && (state == ST_ONE || state == ST_SWAP)));
        push = pkt_valid && !nak;
        pop  = release_hd;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: if (push) state_nx = ST_ONE;
            ST_ONE: begin
                unique case ({push, release_hd})
                    2'b10:   state_nx = ST_TWO;
                    2'b01:   state_nx = ST_EMPTY;
                    2'b11:   state_nx = ST_SWAP;
                    default: state_nx = ST_ONE;
                endcase
            end
            ST_TWO:  if (release_hd) state_nx = ST_SWAP;
            ST_SWAP: state_nx = push ? ST_TWO : ST_ONE;
        endcase
    end

    assert_full_has_rdy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> rdy);
    assert_dis_never_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dbuf_dis && !full) |=> !full);
    assert_nak_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && full) |-> nak);
    assert_gap_then_rdy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWAP) |=> rdy);
    assert_full_release_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && clr_rdy) |=> (!rdy && !full));
    assert_auto_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !full && unload && head_is_max && !pkt_valid) |=> !rdy);
    assert_short_keeps_rdy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && unload && !head_is_max && !clr_rdy) |=> rdy);
    assert_idle_stays_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMPTY && !pkt_valid) |=> (state == ST_EMPTY));
endmodule

// File: rtl/rxbuf_status_ctrl.sv
module rxbuf_status_ctrl
    import rxbuf_pkg::*;
#(
    parameter int MAX_PKT = 64,
    parameter int CNT_W   = $clog2(MAX_PKT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_valid,
    input  logic [CNT_W-1:0] pkt_bytes,
    input  logic             unload,
    input  logic             clr_rdy,
    input  logic             dbuf_dis,
    output logic             rdy,
    output logic             full,
    output logic [CNT_W-1:0] head_cnt,
    output logic             nak
);
    localparam int NSLOT = 2;
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_PKT);

    rx_state_e        state;
    logic             push, pop, head_is_max;
    logic [CNT_W-1:0] slot_head;

    rxbuf_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pkt_valid   (pkt_valid),
        .unload      (unload),
        .clr_rdy     (clr_rdy),
        .dbuf_dis    (dbuf_dis),
        .head_is_max (head_is_max),
        .state       (state),
        .push        (push),
        .pop         (pop),
        .nak         (nak),
        .rdy         (rdy),
        .full        (full)
    );

    rxbuf_slots #(.CNT_W(CNT_W), .NSLOT(NSLOT)) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_cnt  (pkt_bytes),
        .pop       (pop),
        .slot_head (slot_head)
    );

    assign head_cnt    = (state == ST_EMPTY) ? '0 : slot_head;
    assign head_is_max = (head_cnt == MAX_CNT);

    assert_nak_keeps_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (nak && rdy && !unload && !clr_rdy) |=> $stable(head_cnt));
endmodule

// File: tb/rxbuf_status_ctrl_tb.sv
`timescale 1ns/100ps
module rxbuf_status_ctrl_tb;
    localparam int CW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pkt_valid = 1'b0, unload = 1'b0, clr_rdy = 1'b0, dbuf_dis = 1'b0;
    logic [CW-1:0] pkt_bytes = '0;
    logic          rdy, full, nak;
    logic [CW-1:0] head_cnt;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        logic          rdy;
        logic          full;
        logic [CW-1:0] cnt;
        string         tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    rxbuf_status_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_bytes(pkt_bytes),
        .unload(unload), .clr_rdy(clr_rdy), .dbuf_dis(dbuf_dis),
        .rdy(rdy), .full(full), .head_cnt(head_cnt), .nak(nak)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus, check nak in that cycle, queue the
    // registered outputs expected after the following rising edge.
    task automatic step(input logic pv, input int bytes, input logic unl,
                        input logic clr, input logic dis, input logic e_nak,
                        input logic e_rdy, input logic e_full, input int e_cnt,
                        input string tag);
        exp_t e;
        @(negedge clk);
        pkt_valid = pv; pkt_bytes = CW'(bytes); unload = unl;
        clr_rdy = clr; dbuf_dis = dis;
        #1;
        check({tag, " nak"}, int'(nak), int'(e_nak));
        e.rdy = e_rdy; e.full = e_full; e.cnt = CW'(e_cnt); e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " rdy"},  int'(rdy),  int'(e.rdy));
                check({e.tag, " full"}, int'(full), int'(e.full));
                check({e.tag, " cnt"},  int'(head_cnt), int'(e.cnt));
            end
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        dbuf_dis = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check("R1 rdy", int'(rdy), 0);
        check("R1 full", int'(full), 0);
        check("R1 cnt", int'(head_cnt), 0);
        check("R1 nak", int'(nak), 0);
        rst_n = 1'b1;
        //    pv bytes unl clr dis nak rdy full cnt
        step(0, 0,  0, 1, 0, 0, 0, 0, 0,  "R9 clr while empty");
        step(0, 0,  1, 0, 0, 0, 0, 0, 0,  "R10 unload while empty");
        step(1, 64, 0, 0, 0, 0, 1, 0, 64, "R2 max packet in");
        step(0, 0,  1, 0, 0, 0, 0, 0, 0,  "R3 auto release");
        step(1, 10, 0, 0, 0, 0, 1, 0, 10, "R2 short packet in");
        step(0, 0,  1, 0, 0, 0, 1, 0, 10, "R4 short unload keeps rdy");
        step(0, 0,  0, 1, 0, 0, 0, 0, 0,  "R4 clr releases");
        step(1, 20, 0, 0, 0, 0, 1, 0, 20, "R2 first of two");
        step(1, 30, 0, 0, 0, 0, 1, 1, 20, "R5 second sets full");
        step(1, 40, 0, 0, 0, 1, 1, 1, 20, "R8 nak when full");
        step(0, 0,  0, 1, 0, 0, 0, 0, 30, "R6 gap after clr while full");
        step(0, 0,  0, 1, 0, 0, 1, 0, 30, "R9 clr in gap ignored");
        step(0, 0,  1, 0, 0, 0, 1, 0, 30, "R4 short unload second");
        step(1, 64, 0, 0, 0, 0, 1, 1, 30, "R5 full again");
        step(0, 0,  0, 1, 0, 0, 0, 0, 64, "R6 gap count moves");
        step(0, 0,  0, 0, 0, 0, 1, 0, 64, "R6 rdy returns");
        step(1, 5,  0, 0, 0, 0, 1, 1, 64, "R5 full head max");
        step(0, 0,  1, 0, 0, 0, 0, 0, 5,  "R3 auto release while full");
        step(0, 0,  0, 0, 0, 0, 1, 0, 5,  "R6 rdy after auto gap");
        step(0, 0,  0, 1, 0, 0, 0, 0, 0,  "R4 clr to empty");
        step(1, 12, 0, 0, 0, 0, 1, 0, 12, "R2 packet 12");
        step(1, 64, 0, 0, 0, 0, 1, 1, 12, "R5 full head short");
        step(0, 0,  0, 1, 0, 0, 0, 0, 64, "R6 gap head max");
        step(0, 0,  1, 0, 0, 0, 1, 0, 64, "R10 unload in gap ignored");
        step(0, 0,  1, 0, 0, 0, 0, 0, 0,  "R3 release max head");
        step(1, 8,  0, 0, 1, 0, 1, 0, 8,  "R2 single mode packet");
        step(1, 9,  0, 0, 1, 1, 1, 0, 8,  "R7 single mode nak");
        step(0, 0,  0, 1, 1, 0, 0, 0, 0,  "R7 single mode release");
        step(0, 0,  0, 0, 1, 0, 0, 0, 0,  "R1 idle end");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule